// File: doc/BRIEF.md
# Fixed-Width Truncated Radix-4 Booth Multiplier

This block multiplies a signed W-bit data sample by a signed coefficient of CW bits (CW no wider than W, even), both two's complement. It is meant for the twiddle rotation stage of a pipelined FFT, where the coefficient changes every sample. The coefficient is recoded into CW/2 radix-4 signed digits drawn from {-2,-1,0,+1,+2}. Each digit selects zero, the data, or twice the data, negated when needed, as one partial-product row.

Only a W-bit result is produced. The product is read as a fraction, with one LSB of the result worth 2^(CW-1) of the integer product. Every partial-product bit below that column is left out of the adder, including the +1 carry-ins of negated rows that land there. In their place a constant K is added at the result LSB. K is the mean value of the dropped bits plus half an LSB for rounding, rounded to a whole LSB. It is 2 for the defaults W=12 and CW=10. A sum that overflows W bits is clamped.

Each accepted operand pair produces its result in a register one cycle later, with a matching valid flag. Pairs may arrive on every cycle.

Top module: `trunc_booth_mul`

## Requirements
- R1: While rst_n is low, out_valid is 0 and product_out is 0.
- R2: out_valid is high in exactly the cycle after a cycle in which in_valid was high. product_out then holds the result for the operands presented in that earlier cycle.
- R3: While in_valid is low, product_out keeps its value whatever data_in and coef_in carry, and out_valid is 0.
- R4: For defaults (W=12, CW=10), the result r satisfies |r*512 - data_in*coef_in| <= 4*512 for all operand pairs, so the error is within 4 result LSBs.
- R5: Over uniformly random operands, the mean of r*512 - data_in*coef_in lies within one result LSB (512) of zero, showing that the compensation constant removes the truncation offset.
- R6: A zero coefficient gives exactly K (2 for defaults) for any data value.
- R7: A coefficient of +1 gives exactly floor(data_in / 2^(CW-1)) + K. The division is arithmetic, rounding toward minus infinity.
- R8: Most-negative data times most-negative coefficient (-2048 x -512 for defaults) gives 2^(W-1)-1 (2047), not a wrapped negative value.
- R9: Operand pairs on consecutive cycles each produce their own result on the following cycle, with no bubble and no mixing between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair on data_in and coef_in is valid |
| data_in | input | W | Signed data sample |
| coef_in | input | CW | Signed coefficient, recoded into radix-4 digits |
| out_valid | output | 1 | product_out was loaded on the last edge |
| product_out | output | W | Signed fixed-width product with compensation and clamp |

## Verification
Two things can happen in the same cycle: the compensation constant is added, and the clamp fires. In the most-negative corner, K pushes an already out-of-range sum further past the limit, so the clamp has to catch the biased sum and not the raw one. The bench sends that corner in the middle of a back-to-back stream, between ordinary vectors. It checks for exactly 2047 there and checks the exact R6/R7 values on the neighbouring cycles. The same corner also runs through the error-bound check, so a clamp placed before the bias, or one missing entirely, shows up as a miscompare.

// File: rtl/trunc_booth_pkg.sv
package trunc_booth_pkg;

    // One radix-4 recoded digit: nz = digit non-zero, dbl = magnitude 2, neg = negative
    typedef struct packed {
        logic neg;
        logic dbl;
        logic nz;
    } bdig_t;

    // Compensation constant in result LSBs for a coefficient of cw bits.
    // Dropped columns are 0 .. cw-2. Column c holds floor(c/2)+1 row bits,
    // plus one negation carry when c is even. Each bit is taken as 1 with
    // probability 3/8. Half an LSB is added for rounding, then the total is
    // rounded to the nearest whole LSB (weight 2^(cw-1)).
    function automatic int fw_bias(input int cw);
        int d;
        longint acc8;
        longint lsb;
        d    = cw - 1;
        lsb  = longint'(1) << d;
        acc8 = 4 * lsb;
        for (int c = 0; c < d; c++) begin
            acc8 += 3 * longint'((c / 2) + 1 + ((c % 2 == 0) ? 1 : 0)) * (longint'(1) << c);
        end
        return int'((acc8 + 4 * lsb) / (8 * lsb));
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import trunc_booth_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic [CW-1:0] coef,
    output bdig_t         digs [CW/2]
);
    localparam int ND = CW / 2;

    logic [CW:0] cx;
    assign cx = {coef, 1'b0};

    for (genvar i = 0; i < ND; i++) begin : g_dig
        logic [2:0] grp;
        assign grp = cx[2*i+2 : 2*i];
        always_comb begin
            unique case (grp)
                3'b001, 3'b010: digs[i] = '{neg: 1'b0, dbl: 1'b0, nz: 1'b1};
                3'b011:         digs[i] = '{neg: 1'b0, dbl: 1'b1, nz: 1'b1};
                3'b100:         digs[i] = '{neg: 1'b1, dbl: 1'b1, nz: 1'b1};
                3'b101, 3'b110: digs[i] = '{neg: 1'b1, dbl: 1'b0, nz: 1'b1};
                default:        digs[i] = '{neg: 1'b0, dbl: 1'b0, nz: 1'b0};
            endcase
        end
    end
endmodule

// File: rtl/booth_pp_row.sv
module booth_pp_row
    import trunc_booth_pkg::*;
#(
    parameter int W     = 12,
    parameter int P     = 23,
    parameter int SHIFT = 0,
    parameter int D     = 9
) (
    input  logic [W-1:0] data,
    input  bdig_t        dig,
    output logic [P-1:0] row
);
    localparam logic [P-1:0] KEEP = {P{1'b1}} << D;

    logic [W:0]   mag;
    logic [W:0]   sel;
    logic [P-1:0] ext;
    logic [P-1:0] kept;

    always_comb begin
        mag  = dig.dbl ? {data, 1'b0} : {data[W-1], data};
        sel  = !dig.nz ? '0 : (dig.neg ? ~mag : mag);
        ext  = {{(P-W-1){sel[W]}}, sel};
        kept = (ext << SHIFT) & KEEP;
    end

    if (SHIFT >= D) begin : g_carry_kept
        assign row = kept + ({{(P-1){1'b0}}, dig.neg & dig.nz} << SHIFT);
    end else begin : g_carry_dropped
        assign row = kept;
    end
endmodule

// File: rtl/trunc_accum.sv
module trunc_accum #(
    parameter int W  = 12,
    parameter int P  = 23,
    parameter int ND = 5,
    parameter int D  = 9,
    parameter int K  = 2
) (
    input  logic [P-1:0] rows [ND],
    output logic [W-1:0] result
);
    localparam int MAXV = (1 << (W-1)) - 1;
    localparam logic signed [P-1:0] HI   = P'(MAXV);
    localparam logic signed [P-1:0] LO   = P'(-MAXV - 1);
    localparam logic [P-1:0]        BIAS = P'(K) << D;

    logic        [P-1:0] sum;
    logic signed [P-1:0] sh;

    always_comb begin
        sum = BIAS;
        for (int i = 0; i < ND; i++) begin
            sum = sum + rows[i];
        end
        sh = $signed(sum) >>> D;
        if (sh > HI)      result = HI[W-1:0];
        else if (sh < LO) result = LO[W-1:0];
        else              result = sh[W-1:0];
    end
endmodule

// File: rtl/trunc_booth_mul.sv
module trunc_booth_mul
    import trunc_booth_pkg::*;
#(
    parameter int W  = 12,
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  data_in,
    input  logic [CW-1:0] coef_in,
    output logic          out_valid,
    output logic [W-1:0]  product_out
);
    localparam int ND = CW / 2;
    localparam int D  = CW - 1;
    localparam int P  = W + CW + 1;
    localparam int K  = fw_bias(CW);
    localparam logic [W-1:0]  DMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [CW-1:0] CMIN = {1'b1, {(CW-1){1'b0}}};
    localparam logic [W-1:0]  DMAX = {1'b0, {(W-1){1'b1}}};

    typedef struct packed {
        logic         vld;
        logic [W-1:0] prod;
    } state_t;

    state_t state_d, state_q;

    bdig_t          digs [ND];
    logic [P-1:0]   rows [ND];
    logic [W-1:0]   comb_prod;

    booth_recoder #(.CW(CW)) u_rec (
        .coef (coef_in),
        .digs (digs)
    );

    for (genvar i = 0; i < ND; i++) begin : g_row
        booth_pp_row #(.W(W), .P(P), .SHIFT(2*i), .D(D)) u_row (
            .data (data_in),
            .dig  (digs[i]),
            .row  (rows[i])
        );
    end

    trunc_accum #(.W(W), .P(P), .ND(ND), .D(D), .K(K)) u_acc (
        .rows   (rows),
        .result (comb_prod)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.prod = comb_prod;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid   = state_q.vld;
    assign product_out = state_q.prod;

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == ($past(in_valid) && $past(rst_n)));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(in_valid) && $past(rst_n)) |-> $stable(product_out));

    assert_zero_coef_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && rst_n && coef_in == '0) |-> product_out == W'(K));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && rst_n && data_in == DMIN && coef_in == CMIN) |-> product_out == DMAX);

endmodule

// File: tb/trunc_booth_mul_tb.sv
module trunc_booth_mul_tb_top;
    localparam int  W       = 12;
    localparam int  CW      = 10;
    localparam int  LSBW    = 512;
    localparam time CLK_PER = 10ns;
    localparam int  NRAND   = 2000;

    typedef struct packed {
        logic signed [W-1:0]  a;
        logic signed [CW-1:0] b;
        logic signed [W-1:0]  e;
    } vec_t;

    // R6: zero coefficient -> 2; R7: coefficient 1 -> floor(a/512)+2; R8: corner -> 2047
    localparam vec_t VECS [10] = '{
        '{12'sd1000,   10'sd1,    12'sd3},
        '{-12'sd1000,  10'sd1,    12'sd0},
        '{12'sd2047,   10'sd1,    12'sd5},
        '{-12'sd2048,  10'sd1,   -12'sd2},
        '{-12'sd2048, -10'sd512,  12'sd2047},
        '{12'sd511,    10'sd1,    12'sd2},
        '{12'sd512,    10'sd1,    12'sd3},
        '{12'sd1234,   10'sd0,    12'sd2},
        '{-12'sd2048,  10'sd0,    12'sd2},
        '{12'sd0,      10'sd0,    12'sd2}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  data_in = '0;
    logic [CW-1:0] coef_in = '0;
    logic          out_valid;
    logic [W-1:0]  product_out;

    int n_chk = 0;
    int n_bad = 0;
    longint err_sum = 0;

    always #(CLK_PER/2) clk = ~clk;

    trunc_booth_mul #(.W(W), .CW(CW)) dut_i (
        .clk, .rst_n, .in_valid, .data_in, .coef_in, .out_valid, .product_out
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_bound(input logic signed [W-1:0] a, input logic signed [CW-1:0] b);
        longint err;
        err = longint'($signed(product_out)) * LSBW - longint'(a) * longint'(b);
        err_sum += err;
        n_chk++;
        if (err > 4*LSBW || err < -4*LSBW) begin
            n_bad++;
            $display("FAIL R4 a=%0d b=%0d actual=%0d expected within +-%0d of %0d",
                     a, b, err, 4*LSBW, 0);
        end
    endtask

    // Drive at negedge; result registered at next posedge; sample at following negedge.
    task automatic apply(input logic signed [W-1:0] a, input logic signed [CW-1:0] b);
        in_valid = 1'b1;
        data_in  = a;
        coef_in  = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] held;
        void'($urandom(7));
        repeat (3) @(negedge clk);
        check("R1 out_valid", out_valid, 0);
        check("R1 product_out", product_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walked back to back (R9 streaming, R2 latency)
        foreach (VECS[i]) begin
            apply(VECS[i].a, VECS[i].b);
            check("R2 out_valid", out_valid, 1);
            check($sformatf("R9 vec%0d", i), $signed(product_out), VECS[i].e);
            check_bound(VECS[i].a, VECS[i].b);
        end

        // R3: idle with changing operands
        held = product_out;
        in_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            data_in = W'(k * 333 + 17);
            coef_in = CW'(k * 91 + 5);
            @(negedge clk);
            check("R3 out_valid", out_valid, 0);
            check("R3 hold", product_out, held);
        end

        // R8 corner surrounded by ordinary vectors in a stream
        apply(12'sd1000, 10'sd1);
        check("R7 pre", $signed(product_out), 3);
        apply(-12'sd2048, -10'sd512);
        check("R8 saturate", $signed(product_out), 2047);
        apply(12'sd777, 10'sd0);
        check("R6 post", $signed(product_out), 2);

        // R2: single pulse
        in_valid = 1'b0;
        @(negedge clk);
        apply(12'sd512, 10'sd1);
        check("R2 pulse valid", out_valid, 1);
        check("R7 pulse value", $signed(product_out), 3);
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 pulse drop", out_valid, 0);

        // R4/R5 random operands
        err_sum = 0;
        for (int k = 0; k < NRAND; k++) begin
            logic signed [W-1:0]  ra;
            logic signed [CW-1:0] rb;
            ra = W'($urandom);
            rb = CW'($urandom);
            apply(ra, rb);
            check_bound(ra, rb);
        end
        n_chk++;
        if (err_sum > longint'(NRAND) * LSBW || err_sum < -longint'(NRAND) * LSBW) begin
            n_bad++;
            $display("FAIL R5 mean error sum actual=%0d expected within +-%0d",
                     err_sum, longint'(NRAND) * LSBW);
        end

        in_valid = 1'b0;
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule